// File: doc/BRIEF.md
# Status Register Write-Protect Guard

This block keeps the protection state of a serial memory device: a write-enable latch, a busy flag, a two-bit block-protect code and a hardware-protect enable bit. These are presented as one readable status byte. The block decides in the same cycle whether a requested status-register update may go ahead. It also decides whether a program or erase aimed at an 18-bit byte address may go ahead.

The command decoder pulses strobes to set or clear the write-enable latch and to request a status update with a data byte. The array sequencer pulses a start strobe when a program or erase begins and a done strobe when it ends. The level of the active-low write-protect pin is read in the cycle a status update is committed. A committed status update starts an internal cycle of its own, which the sequencer ends with the same done strobe.

Top module: `wp_status_guard`

## Requirements
- R1: The status byte reads {hpe, 0, 0, 0, bp[1], bp[0], wel, busy}, with bit 7 hpe, bits 6 to 4 always 0, bits 3:2 the protect code, bit 1 the write-enable latch and bit 0 busy (1 = internal cycle running). Reset leaves it at 0x00.
- R2: When idle, `wrEnSet` sets the write-enable latch and `wrEnClr` clears it on the next edge. If both are pulsed in the same cycle, the clear wins.
- R3: `statWrGrant` is 1 exactly when the block is idle, the latch is set, and either `wpPinN` is 1 or hpe is 0. A granted `statWrReq` loads hpe from data bit 7 and the protect code from data bits 3:2, and sets busy on the next edge. Data bits 6:4, 1 and 0 are ignored.
- R4: A status request that is not granted changes nothing. In particular, with `wpPinN` low and hpe at 1, hpe cannot be cleared.
- R5: When idle, `busySet` sets busy. When busy, `busyClr` clears both busy and the write-enable latch on the next edge.
- R6: While busy, `wrEnSet`, `wrEnClr`, `statWrReq` and `busySet` have no effect, and both grants read 0.
- R7: `arrGrant` for a non-bulk operation is 0 when `opAddr` lies in the protected range. Code 00 protects nothing. Code 01 protects 0x30000 to 0x3FFFF. Code 10 protects 0x20000 to 0x3FFFF. Code 11 protects 0x00000 to 0x3FFFF.
- R8: With `opBulk` high, `arrGrant` can be 1 only when the protect code is 00.
- R9: `arrGrant` is 0 whenever the write-enable latch is clear.
- R10: The pin matters only in the commit cycle. A pin drop after a granted status write does not undo the loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEnSet | input | 1 | Set write-enable latch strobe |
| wrEnClr | input | 1 | Clear write-enable latch strobe |
| statWrReq | input | 1 | Status-register write request strobe |
| statWrData | input | 8 | Status byte to be written |
| busySet | input | 1 | Program/erase cycle start from sequencer |
| busyClr | input | 1 | Internal cycle completion from sequencer |
| wpPinN | input | 1 | Write-protect pin level, low protects |
| opAddr | input | 18 | Target byte address of a program/erase |
| opBulk | input | 1 | Target operation is a whole-array erase |
| statusByte | output | 8 | Readable status byte |
| statWrGrant | output | 1 | Status write would be accepted this cycle |
| arrGrant | output | 1 | Program/erase to opAddr is permitted |

## Verification
The properties assume that `busyClr` arrives only while the busy bit is set. They also assume that start and done strobes never appear in the same cycle. The stimulus follows this: it raises `busySet` only from idle and closes every cycle with a single `busyClr`. The strobes are one-cycle pulses driven between edges. The pin is held at one level around each commit edge, except in the case that deliberately drops it after a grant, so the first-cycle sampling is exercised on purpose.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadStat;
    logic setBusy;
    logic clrBusy;
  } guardStrobes_t;

  typedef enum logic [1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } protCode_e;

  localparam int HPE_BIT  = 7;
  localparam int BP_HI    = 3;
  localparam int BP_LO    = 2;
  localparam int WEL_BIT  = 1;
  localparam int BUSY_BIT = 0;
endpackage

// File: rtl/wp_range_check.sv
module wp_range_check
  import wp_guard_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              isBulk,
  input  logic [1:0]        protCode,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] QTR_BASE  = {2'b11, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] HALF_BASE = {1'b1, {(ADDR_W-1){1'b0}}};

  logic inRange;

  always_comb begin
    unique case (protCode_e'(protCode))
      PROT_NONE:    inRange = 1'b0;
      PROT_QUARTER: inRange = (addr >= QTR_BASE);
      PROT_HALF:    inRange = (addr >= HALF_BASE);
      default:      inRange = 1'b1;
    endcase
  end

  assign hit = isBulk ? (protCode != PROT_NONE) : inRange;
endmodule

// File: rtl/wp_guard_ctrl.sv
module wp_guard_ctrl
  import wp_guard_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              wrEnSet,
  input  logic              wrEnClr,
  input  logic              statWrReq,
  input  logic              busySet,
  input  logic              busyClr,
  input  logic              wpPinN,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic              opBulk,
  input  logic              curHpe,
  input  logic [1:0]        curBp,
  input  logic              curWel,
  input  logic              curBusy,
  output guardStrobes_t     strb,
  output logic              statWrGrant,
  output logic              arrGrant
);
  logic idle;
  logic protHit;
  logic pinBlocks;

  wp_range_check #(.ADDR_W(ADDR_W)) i_range (
    .addr     (opAddr),
    .isBulk   (opBulk),
    .protCode (curBp),
    .hit      (protHit)
  );

  assign idle        = !curBusy;
  assign pinBlocks   = !wpPinN && curHpe;
  assign statWrGrant = idle && curWel && !pinBlocks;
  assign arrGrant    = idle && curWel && !protHit;

  always_comb begin
    strb          = '0;
    strb.loadStat = statWrReq && statWrGrant;
    strb.setBusy  = idle && (busySet || strb.loadStat);
    strb.clrBusy  = curBusy && busyClr;
    strb.clrWel   = strb.clrBusy || (idle && wrEnClr);
    strb.setWel   = idle && wrEnSet && !wrEnClr;
  end
endmodule

// File: rtl/wp_guard_dp.sv
module wp_guard_dp
  import wp_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  guardStrobes_t strb,
  input  logic [7:0]    statWrData,
  output logic          curHpe,
  output logic [1:0]    curBp,
  output logic          curWel,
  output logic          curBusy,
  output logic [7:0]    statusByte
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curHpe <= 1'b0;
      curBp  <= 2'b00;
    end else if (strb.loadStat) begin
      curHpe <= statWrData[HPE_BIT];
      curBp  <= statWrData[BP_HI:BP_LO];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             curWel <= 1'b0;
    else if (strb.clrWel)  curWel <= 1'b0;
    else if (strb.setWel)  curWel <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             curBusy <= 1'b0;
    else if (strb.clrBusy) curBusy <= 1'b0;
    else if (strb.setBusy) curBusy <= 1'b1;
  end

  always_comb begin
    statusByte           = '0;
    statusByte[HPE_BIT]  = curHpe;
    statusByte[BP_HI:BP_LO] = curBp;
    statusByte[WEL_BIT]  = curWel;
    statusByte[BUSY_BIT] = curBusy;
  end
endmodule

// File: rtl/wp_status_guard.sv
module wp_status_guard
  import wp_guard_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEnSet,
  input  logic              wrEnClr,
  input  logic              statWrReq,
  input  logic [7:0]        statWrData,
  input  logic              busySet,
  input  logic              busyClr,
  input  logic              wpPinN,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic              opBulk,
  output logic [7:0]        statusByte,
  output logic              statWrGrant,
  output logic              arrGrant
);
  guardStrobes_t strb;
  logic          curHpe;
  logic [1:0]    curBp;
  logic          curWel;
  logic          curBusy;

  wp_guard_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .wrEnSet     (wrEnSet),
    .wrEnClr     (wrEnClr),
    .statWrReq   (statWrReq),
    .busySet     (busySet),
    .busyClr     (busyClr),
    .wpPinN      (wpPinN),
    .opAddr      (opAddr),
    .opBulk      (opBulk),
    .curHpe      (curHpe),
    .curBp       (curBp),
    .curWel      (curWel),
    .curBusy     (curBusy),
    .strb        (strb),
    .statWrGrant (statWrGrant),
    .arrGrant    (arrGrant)
  );

  wp_guard_dp i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .statWrData (statWrData),
    .curHpe     (curHpe),
    .curBp      (curBp),
    .curWel     (curWel),
    .curBusy    (curBusy),
    .statusByte (statusByte)
  );
endmodule

// File: rtl/wp_status_guard_chk.sv
module wp_status_guard_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEnSet,
  input logic              wrEnClr,
  input logic              statWrReq,
  input logic [7:0]        statWrData,
  input logic              busySet,
  input logic              busyClr,
  input logic              wpPinN,
  input logic [ADDR_W-1:0] opAddr,
  input logic              opBulk,
  input logic [7:0]        statusByte,
  input logic              statWrGrant,
  input logic              arrGrant
);
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[6:4] == 3'b000);

  assert_wel_rise_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[1]) |-> $past(wrEnSet));

  assert_pin_lock_R4: assert property (@(posedge clk) disable iff (!rstN)
    (statWrReq && !wpPinN && statusByte[7]) |=> $stable(statusByte[7:2]));

  assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[0] && busyClr) |=> (statusByte[1:0] == 2'b00));

  assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[0] |-> (!statWrGrant && !arrGrant));

  assert_bulk_needs_open_R8: assert property (@(posedge clk) disable iff (!rstN)
    (arrGrant && opBulk) |-> (statusByte[3:2] == 2'b00));

  assert_grant_needs_wel_R9: assert property (@(posedge clk) disable iff (!rstN)
    arrGrant |-> statusByte[1]);
endmodule

bind wp_status_guard wp_status_guard_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_wp_status_guard.sv
module test_wp_status_guard;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEnSet, wrEnClr, statWrReq, busySet, busyClr, wpPinN, opBulk;
  logic [7:0]  statWrData;
  logic [17:0] opAddr;
  logic [7:0]  statusByte;
  logic        statWrGrant, arrGrant;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  int mHpe = 0, mBp = 0, mWel = 0, mBusy = 0;

  always #5 clk = ~clk;

  wp_status_guard i_wp_status_guard (
    .clk, .rstN, .wrEnSet, .wrEnClr, .statWrReq, .statWrData,
    .busySet, .busyClr, .wpPinN, .opAddr, .opBulk,
    .statusByte, .statWrGrant, .arrGrant
  );

  function automatic int expStatus();
    return (mHpe << 7) | (mBp << 2) | (mWel << 1) | mBusy;
  endfunction

  function automatic int expStatGrant();
    return (mBusy == 0 && mWel == 1 && (wpPinN == 1'b1 || mHpe == 0)) ? 1 : 0;
  endfunction

  function automatic int expArrGrant();
    int a;
    bit locked;
    a = int'(opAddr);
    if (opBulk) locked = (mBp != 0);
    else case (mBp)
      0: locked = 0;
      1: locked = (a >= 'h30000);
      2: locked = (a >= 'h20000);
      default: locked = 1;
    endcase
    return (mBusy == 0 && mWel == 1 && !locked) ? 1 : 0;
  endfunction

  // behavioural reference, advanced on each edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) begin
      mHpe <= 0; mBp <= 0; mWel <= 0; mBusy <= 0;
    end else if (mBusy == 1) begin
      if (busyClr) begin mBusy <= 0; mWel <= 0; end
    end else begin
      if (statWrReq && expStatGrant() == 1) begin
        mHpe <= statWrData[7]; mBp <= int'(statWrData[3:2]); mBusy <= 1;
      end else if (busySet) mBusy <= 1;
      if (wrEnClr) mWel <= 0;
      else if (wrEnSet) mWel <= 1;
    end
  end

  task automatic idleIns();
    wrEnSet = 0; wrEnClr = 0; statWrReq = 0; busySet = 0; busyClr = 0;
    statWrData = 8'h00; opBulk = 0;
  endtask

  // compare outputs mid-cycle, then pass one edge
  task automatic tick(input string tag);
    #2;
    checks++;
    if (int'(statusByte) != expStatus()) begin
      fails++;
      $display("FAIL %s statusByte actual %02h expected %02h", tag, statusByte, expStatus());
    end
    checks++;
    if (int'(statWrGrant) != expStatGrant()) begin
      fails++;
      $display("FAIL %s statWrGrant actual %0d expected %0d", tag, statWrGrant, expStatGrant());
    end
    checks++;
    if (int'(arrGrant) != expArrGrant()) begin
      fails++;
      $display("FAIL %s arrGrant actual %0d expected %0d", tag, arrGrant, expArrGrant());
    end
    @(negedge clk);
    idleIns();
  endtask

  task automatic setProt(input logic [7:0] val);
    wrEnSet = 1; tick("R2 set latch");
    wpPinN = 1; statWrReq = 1; statWrData = val; tick("R3 commit");
    busyClr = 1; tick("R5 done");
    tick("R3 loaded");
  endtask

  task automatic sweep(input string tag);
    int addrs[6] = '{'h00000, 'h1FFFF, 'h20000, 'h2FFFF, 'h30000, 'h3FFFF};
    wrEnSet = 1; tick(tag);
    foreach (addrs[i]) begin
      opAddr = 18'(addrs[i]); tick(tag);
    end
    opBulk = 1; tick("R8 bulk");
    wrEnClr = 1; tick(tag);
  endtask

  initial begin
    rstN = 0; wpPinN = 1; opAddr = '0; idleIns();
    @(negedge clk);
    tick("R1 reset");
    tick("R1 reset");
    rstN = 1;
    tick("R1 after reset");

    wrEnSet = 1; tick("R2 set");
    wrEnClr = 1; tick("R2 clear");
    wrEnSet = 1; wrEnClr = 1; tick("R2 clear wins");
    opAddr = 18'h00100; tick("R9 latch clear deny");
    statWrReq = 1; statWrData = 8'hFF; tick("R4 no latch");

    wrEnSet = 1; tick("R2 set");
    statWrReq = 1; statWrData = 8'h7B; wpPinN = 1; tick("R3 ignored bits");
    wrEnClr = 1; wrEnSet = 1; statWrReq = 1; busySet = 1; tick("R6 busy ignore");
    opAddr = 18'h00000; tick("R6 busy deny");
    busyClr = 1; tick("R5 done");
    tick("R5 cleared");

    setProt(8'h80);
    wpPinN = 0; wrEnSet = 1; tick("R4 latch");
    statWrReq = 1; statWrData = 8'h00; tick("R4 refused");
    tick("R4 hpe kept");
    wpPinN = 1; statWrReq = 1; statWrData = 8'h0C; tick("R10 commit high");
    wpPinN = 0; tick("R10 pin drop");
    busyClr = 1; tick("R10 done");
    tick("R10 kept");
    wpPinN = 1;

    setProt(8'h00); sweep("R7 none");
    setProt(8'h04); sweep("R7 quarter");
    setProt(8'h08); sweep("R7 half");
    setProt(8'h0C); sweep("R7 all");

    setProt(8'h00);
    wpPinN = 0; wrEnSet = 1; tick("R3 pin low hpe off");
    statWrReq = 1; statWrData = 8'h04; tick("R3 pin ignored");
    busyClr = 1; tick("R5 done");
    tick("R3 loaded");
    wrEnSet = 1; tick("R5 start");
    busySet = 1; tick("R5 start");
    tick("R6 busy");
    busyClr = 1; tick("R5 done");
    tick("R5 latch cleared");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    fails++;
    $display("FAIL watchdog actual %0d cycles expected completion", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule